// File: doc/BRIEF.md
# Double-Data-Rate Nibble Link Transceiver

This block carries a byte stream, with a data-valid flag and an error flag, over a four-lane double-data-rate link. On every rising edge of the link clock the transmit half takes in one byte and both flags. It then drives four data lanes, one control lane and a forwarded clock. Each of these outputs changes on both edges of the link clock. The design uses only portable behavioural logic: a clocked register feeds each output lane, and the link clock itself selects between two held values.

The receive half samples the four lanes and the control lane. It takes one sample on the rising edge of a capture clock and one on the falling edge, then rebuilds the byte and both flags. The capture clock is expected to run at the link rate, lagging by a quarter period so that each sample falls in the middle of a half-cycle. Differential buffering, phase generation and delay alignment are left to the surrounding logic. In a loopback the rebuilt byte is ready two link-clock cycles after the byte was presented.

Top module: `ddr_nibble_link`

## Requirements
- R1: While the link clock is high, lane k of `link_dat` carries bit k (bits 3..0) of the byte captured at the most recent rising edge of `clk`.
- R2: While the link clock is low, lane k of `link_dat` carries bit k+4 (bits 7..4) of that same byte, captured at the same rising edge.
- R3: `link_ctl` carries the valid flag while the clock is high and the error flag while it is low, both captured at the same rising edge as the byte.
- R4: `link_clk` is 1 while `clk` is high and 0 while it is low once out of reset, so its edges line up with the data changes.
- R5: The low-phase value comes from a register. A change of `tx_byte` or `tx_err` during the low phase does not alter `link_dat` or `link_ctl` before the next rising edge of `clk`.
- R6: The receiver puts its rising-edge lane sample into bits 3..0 and the following falling-edge sample into bits 7..4, and registers the rebuilt byte on the next rising edge of `rx_clk`. In a loopback with `rx_clk` lagging by a quarter period, `rx_byte` equals the transmitted byte two `clk` cycles after it was presented.
- R7: `rx_en` is the rising-edge control sample and `rx_err` is the falling-edge control sample, copied without decoding. Valid=1 together with error=1 rebuilds as `rx_en`=1 and `rx_err`=1.
- R8: While `rst_n` is low, the outputs `link_dat`, `link_ctl`, `link_clk`, `rx_byte`, `rx_en` and `rx_err` are all 0, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock for the transmit half |
| rst_n | input | 1 | Asynchronous active-low reset for both halves |
| tx_byte | input | 8 | Byte to send, captured on the rising edge of `clk` |
| tx_en | input | 1 | Valid flag sent during the high phase |
| tx_err | input | 1 | Error flag sent during the low phase |
| link_clk | output | 1 | Forwarded clock |
| link_dat | output | 4 | Double-data-rate data lanes |
| link_ctl | output | 1 | Double-data-rate control lane |
| rx_clk | input | 1 | Capture clock for the receive half |
| rx_dat | input | 4 | Incoming data lanes |
| rx_ctl | input | 1 | Incoming control lane |
| rx_byte | output | 8 | Rebuilt byte |
| rx_en | output | 1 | Rebuilt valid flag |
| rx_err | output | 1 | Rebuilt error flag |

## Verification
The assertions check the following on every edge: the phase pattern of the forwarded clock, the high-phase lane values against the captured low nibble, the low-phase lane and control values against the inputs at the previous edge, the path from the rising-edge lane sample to the rebuilt low nibble and valid flag, and the cleared state during reset. The bench scenarios cover the rest. Only they show the falling-edge sample reaching the high nibble and the error flag, the two-cycle loopback latency, that an input change in the low phase has no effect, and that valid and error both set stay separate.

// File: rtl/ddr_link_pkg.sv
`timescale 1ns / 1ps
package ddr_link_pkg;
  parameter int unsigned LINK_LANES = 4;
  localparam int unsigned WORD_W = 2 * LINK_LANES;

  typedef logic [LINK_LANES-1:0] lanes_t;
  typedef logic [WORD_W-1:0]     word_t;

  // half sent while the link clock is high
  function automatic lanes_t rise_half(input word_t w);
    return w[LINK_LANES-1:0];
  endfunction

  // half sent while the link clock is low
  function automatic lanes_t fall_half(input word_t w);
    return w[WORD_W-1:LINK_LANES];
  endfunction

  function automatic word_t merge_halves(input lanes_t upper, input lanes_t lower);
    return {upper, lower};
  endfunction
endpackage

// File: rtl/ddr_out_cell.sv
`timescale 1ns / 1ps
module ddr_out_cell #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_d,
  input  logic [W-1:0] fall_d,
  output logic [W-1:0] rise_cap,
  output logic [W-1:0] fall_cap,
  output logic [W-1:0] pin
);
  // both halves taken on the same rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cap <= '0;
      fall_cap <= '0;
    end else begin
      rise_cap <= rise_d;
      fall_cap <= fall_d;
    end
  end

  // the clock level selects which held half reaches the pin
  always_comb pin = clk ? rise_cap : fall_cap;
endmodule

// File: rtl/ddr_in_cell.sv
`timescale 1ns / 1ps
module ddr_in_cell #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] rise_smp,
  output logic [W-1:0] rise_word,
  output logic [W-1:0] fall_word
);
  logic [W-1:0] fall_smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_smp <= '0;
    else        rise_smp <= pin;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_smp <= '0;
    else        fall_smp <= pin;
  end

  // rebuilt pair registered on the next rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_word <= '0;
      fall_word <= '0;
    end else begin
      rise_word <= rise_smp;
      fall_word <= fall_smp;
    end
  end
endmodule

// File: rtl/ddr_link_tx.sv
`timescale 1ns / 1ps
module ddr_link_tx
  import ddr_link_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  word_t  tx_byte,
  input  logic   tx_en,
  input  logic   tx_err,
  output logic   link_clk,
  output lanes_t link_dat,
  output logic   link_ctl
);
  lanes_t lo_in, hi_in;
  lanes_t lo_cap, hi_cap;
  logic   en_cap, err_cap;
  logic   fwd_armed, fwd_low;

  always_comb begin
    lo_in = rise_half(tx_byte);
    hi_in = fall_half(tx_byte);
  end

  for (genvar g = 0; g < LINK_LANES; g++) begin : g_lane
    ddr_out_cell #(.W(1)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_d   (lo_in[g]),
      .fall_d   (hi_in[g]),
      .rise_cap (lo_cap[g]),
      .fall_cap (hi_cap[g]),
      .pin      (link_dat[g])
    );
  end

  ddr_out_cell #(.W(1)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_d   (tx_en),
    .fall_d   (tx_err),
    .rise_cap (en_cap),
    .fall_cap (err_cap),
    .pin      (link_ctl)
  );

  // forwarded clock: constant 1 then constant 0; its high register also marks
  // the first edge after reset
  ddr_out_cell #(.W(1)) u_fwd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_d   (1'b1),
    .fall_d   (1'b0),
    .rise_cap (fwd_armed),
    .fall_cap (fwd_low),
    .pin      (link_clk)
  );

  // values sampled at a falling edge show the high phase
  p_lo_phase_r1: assert property (@(negedge clk) disable iff (!rst_n)
    fwd_armed |-> link_dat == lo_cap);
  p_ctl_en_r3: assert property (@(negedge clk) disable iff (!rst_n)
    fwd_armed |-> link_ctl == en_cap);
  p_fwd_high_r4: assert property (@(negedge clk) disable iff (!rst_n)
    fwd_armed |-> link_clk);
  // values sampled at a rising edge show the low phase of the previous cycle
  p_fwd_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !link_clk);
  p_hi_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_armed |-> link_dat == fall_half($past(tx_byte)));
  p_ctl_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_armed |-> link_ctl == $past(tx_err));
  p_tx_reset_r8: assert property (@(posedge clk)
    !rst_n |-> (link_dat == '0 && !link_ctl && !link_clk &&
                hi_cap == '0 && !err_cap && !fwd_low));
endmodule

// File: rtl/ddr_link_rx.sv
`timescale 1ns / 1ps
module ddr_link_rx
  import ddr_link_pkg::*;
(
  input  logic   rx_clk,
  input  logic   rst_n,
  input  lanes_t rx_dat,
  input  logic   rx_ctl,
  output word_t  rx_byte,
  output logic   rx_en,
  output logic   rx_err
);
  lanes_t lane_smp, lane_rise, lane_fall;
  logic   ctl_smp;
  logic [1:0] warm;

  for (genvar g = 0; g < LINK_LANES; g++) begin : g_lane
    ddr_in_cell #(.W(1)) u_cell (
      .clk       (rx_clk),
      .rst_n     (rst_n),
      .pin       (rx_dat[g]),
      .rise_smp  (lane_smp[g]),
      .rise_word (lane_rise[g]),
      .fall_word (lane_fall[g])
    );
  end

  ddr_in_cell #(.W(1)) u_ctl (
    .clk       (rx_clk),
    .rst_n     (rst_n),
    .pin       (rx_ctl),
    .rise_smp  (ctl_smp),
    .rise_word (rx_en),
    .fall_word (rx_err)
  );

  always_comb rx_byte = merge_halves(lane_fall, lane_rise);

  // counts capture edges since reset, saturating, so the history checks stay
  // inside the cycles after reset
  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n)             warm <= '0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  p_rebuild_lo_r6: assert property (@(posedge rx_clk) disable iff (!rst_n)
    warm == 2'd3 |-> rise_half(rx_byte) == $past(rx_dat, 2));
  p_smp_to_byte_r6: assert property (@(posedge rx_clk) disable iff (!rst_n)
    warm != 2'd0 |=> rise_half(rx_byte) == $past(lane_smp));
  p_rebuild_en_r7: assert property (@(posedge rx_clk) disable iff (!rst_n)
    warm == 2'd3 |-> rx_en == $past(rx_ctl, 2));
  p_en_from_smp_r7: assert property (@(posedge rx_clk) disable iff (!rst_n)
    warm != 2'd0 |=> rx_en == $past(ctl_smp));
  p_rx_reset_r8: assert property (@(posedge rx_clk)
    !rst_n |-> (rx_byte == '0 && !rx_en && !rx_err));
endmodule

// File: rtl/ddr_nibble_link.sv
`timescale 1ns / 1ps
module ddr_nibble_link
  import ddr_link_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  tx_byte,
  input  logic        tx_en,
  input  logic        tx_err,
  output logic        link_clk,
  output logic [3:0]  link_dat,
  output logic        link_ctl,
  input  logic        rx_clk,
  input  logic [3:0]  rx_dat,
  input  logic        rx_ctl,
  output logic [7:0]  rx_byte,
  output logic        rx_en,
  output logic        rx_err
);
  ddr_link_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_byte  (tx_byte),
    .tx_en    (tx_en),
    .tx_err   (tx_err),
    .link_clk (link_clk),
    .link_dat (link_dat),
    .link_ctl (link_ctl)
  );

  ddr_link_rx u_rx (
    .rx_clk  (rx_clk),
    .rst_n   (rst_n),
    .rx_dat  (rx_dat),
    .rx_ctl  (rx_ctl),
    .rx_byte (rx_byte),
    .rx_en   (rx_en),
    .rx_err  (rx_err)
  );
endmodule

// File: tb/ddr_nibble_link_test.sv
`timescale 1ns / 1ps
module ddr_nibble_link_test;
  logic       clk = 1'b0;
  logic       rx_clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_en = 1'b0;
  logic       tx_err = 1'b0;
  logic       link_clk, link_ctl, rx_en, rx_err;
  logic [3:0] link_dat;
  logic [7:0] rx_byte;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  logic [7:0] prev_b = 8'h00;
  logic       prev_en = 1'b0;
  logic       prev_err = 1'b0;

  // loopback: the link feeds the receiver
  ddr_nibble_link uut (
    .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .tx_en(tx_en), .tx_err(tx_err),
    .link_clk(link_clk), .link_dat(link_dat), .link_ctl(link_ctl),
    .rx_clk(rx_clk), .rx_dat(link_dat), .rx_ctl(link_ctl),
    .rx_byte(rx_byte), .rx_en(rx_en), .rx_err(rx_err)
  );

  initial forever #5 clk = ~clk;
  initial begin
    #2.5;
    forever #5 rx_clk = ~rx_clk;   // quarter-period lag
  end

  function automatic logic [3:0] low_nib(input logic [7:0] b);
    return 4'(b % 16);
  endfunction
  function automatic logic [3:0] high_nib(input logic [7:0] b);
    return 4'(b / 16);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // called during a low phase of clk
  task automatic step(input logic [7:0] b, input logic en, input logic err);
    tx_byte = b; tx_en = en; tx_err = err;
    #1;
    // R5: the new input must not reach the low-phase lanes yet
    chk("R5 hold dat", {4'h0, link_dat}, {4'h0, high_nib(prev_b)});
    chk("R5 hold ctl", {7'h0, link_ctl}, {7'h0, prev_err});
    @(posedge clk); #2;
    chk("R1 high-phase dat", {4'h0, link_dat}, {4'h0, low_nib(b)});
    chk("R3 high-phase ctl", {7'h0, link_ctl}, {7'h0, en});
    chk("R4 clk high", {7'h0, link_clk}, 8'h01);
    @(negedge clk); #2;
    chk("R2 low-phase dat", {4'h0, link_dat}, {4'h0, high_nib(b)});
    chk("R3 low-phase ctl", {7'h0, link_ctl}, {7'h0, err});
    chk("R4 clk low", {7'h0, link_clk}, 8'h00);
    // R6/R7: previous byte has come back through the loop
    chk("R6 rx_byte", rx_byte, prev_b);
    chk("R7 rx_en", {7'h0, rx_en}, {7'h0, prev_en});
    chk("R7 rx_err", {7'h0, rx_err}, {7'h0, prev_err});
    prev_b = b; prev_en = en; prev_err = err;
  endtask

  task automatic chk_reset(input string tag);
    chk({"R8 link_dat ", tag}, {4'h0, link_dat}, 8'h00);
    chk({"R8 link_ctl ", tag}, {7'h0, link_ctl}, 8'h00);
    chk({"R8 link_clk ", tag}, {7'h0, link_clk}, 8'h00);
    chk({"R8 rx_byte ", tag}, rx_byte, 8'h00);
    chk({"R8 rx flags ", tag}, {6'h0, rx_en, rx_err}, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 chk_reset("high phase");
    @(negedge clk); #2;
    chk_reset("low phase");
    rst_n = 1'b1;

    // directed corners
    step(8'hFF, 1'b1, 1'b0);
    step(8'h00, 1'b0, 1'b1);   // error without valid
    step(8'hA5, 1'b1, 1'b1);   // R7: both set, no decoding
    step(8'h5A, 1'b0, 1'b0);
    step(8'h0F, 1'b1, 1'b0);
    step(8'hF0, 1'b1, 1'b1);
    step(8'h3C, 1'b0, 1'b1);

    for (int i = 0; i < 150; i++)
      step(8'($urandom), 1'($urandom), 1'($urandom));

    // reset in mid stream clears everything without an edge
    rst_n = 1'b0;
    #1 chk_reset("async low");
    @(posedge clk); #2;
    chk_reset("async high");
    @(negedge clk); #2;
    rst_n = 1'b1;
    prev_b = 8'h00; prev_en = 1'b0; prev_err = 1'b0;

    step(8'hC3, 1'b1, 1'b1);
    for (int i = 0; i < 150; i++)
      step(8'($urandom), 1'($urandom), 1'($urandom));
    step(8'h00, 1'b0, 1'b0);

    finish_run();
  end
endmodule